// File: doc/BRIEF.md
# System Control Coprocessor Register Unit

This block is the register side of a processor's system control coprocessor. A register-move access names a register number and an operation sub-code. Together they pick one of four actions: a storage register (system control, page table base, fault status or fault address) is written or read, a fixed identification or cache type word is read, a cache or TLB maintenance command is fired, or the access is flagged as illegal.

Writes to the maintenance registers store nothing. They are decoded into single-clock command pulses for the cache and TLB controllers. For line operations the write data is forwarded as the line address. Read data is combinational and valid in the cycle of the read strobe. Command, TLB and error pulses are registered and appear in the clock cycle after the strobe. The unit also gives the interrupt-take decision from a hardware request and the status-register disable bit.

Top module: `ctlcop_unit`

## Requirements
- R1: A synchronous active-high reset clears the four storage registers (numbers 1 to 4) to zero and holds cache_cmd, line_addr, tlb_flush and access_err at zero.
- R2: A write to register 1, 2, 3 or 4 with operation 0 stores wdata. A read of the same register with operation 0 returns it on rdata in the same cycle as rd_en.
- R3: A write to register 1 to 4 with a non-zero operation leaves the stored value unchanged and raises access_err.
- R4: Reading register 0 returns ID_WORD for operation 0 and CTYPE_WORD for operation 1. Every read other than those and registers 1 to 4 with operation 0 returns zero, and access_err pulses one cycle later. rdata is zero while rd_en is low.
- R5: A write to register 5 sets one bit of cache_cmd, one cycle after the write, for one cycle. The bit depends on the operation: 28 sets bit 0 (invalidate both caches), 20 sets bit 1 (invalidate instruction cache), 12 sets bit 2 (invalidate data cache), 10 sets bit 3 (clean data cache), 14 sets bit 4 (flush data cache), 13 sets bit 5 (invalidate line), 11 sets bit 6 (clean line) and 15 sets bit 7 (flush line). Any other operation on register 5 gives no pulse and no error.
- R6: While bit 5, 6 or 7 of cache_cmd is high, line_addr carries the wdata of the causing write. Otherwise line_addr is zero.
- R7: A write to register 6 with an operation from 2 to 6 inclusive pulses tlb_flush one cycle later. Other operations on register 6 give no pulse and no error.
- R8: A write to register 0 or 7 raises access_err one cycle later and changes no stored value.
- R9: irq_take is high exactly when irq_req is high and irq_mask is low, in the same cycle.
- R10: Every pulse lasts exactly one clock. Writes on consecutive cycles give pulses on consecutive cycles, each matching its own write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| reg_sel | input | REG_W (3) | Coprocessor register number |
| op_code | input | OP_W (5) | Operation sub-code |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Combinational read data |
| cache_cmd | output | 8 | One-hot cache maintenance pulses |
| line_addr | output | DATA_W (32) | Line address for line commands |
| tlb_flush | output | 1 | Full TLB invalidate pulse |
| access_err | output | 1 | Unrecognized access pulse |
| irq_req | input | 1 | Hardware interrupt request |
| irq_mask | input | 1 | Interrupt-disable bit from the status register |
| irq_take | output | 1 | Interrupt exception is to be taken |

## Verification
The bench writes and then reads every register number with every operation code. This catches a decoder that ignores the sub-code: such a decoder would store data from a non-zero operation on registers 1 to 4, or would let a stray register 5 code pulse a cache command. The sweep also probes the edges of the TLB window at operations 1, 2, 6 and 7, where an off-by-one comparison would flush or fail to flush. It also confirms that register 0 can be read but not written, and that unmatched codes on registers 5 and 6 stay silent instead of erroring. Back-to-back writes show whether a pulse stretches or merges with its neighbour.

// File: rtl/ctlcop_pkg.sv
package ctlcop_pkg;
   localparam int unsigned NUM_CCMD = 8;
   localparam int unsigned NUM_STORE = 4;
   localparam int unsigned REG_ID = 0;
   localparam int unsigned REG_STORE_LO = 1;
   localparam int unsigned REG_CACHE = 5;
   localparam int unsigned REG_TLB = 6;
   localparam int unsigned TLB_OP_LO = 2;
   localparam int unsigned TLB_OP_HI = 6;
   localparam logic [NUM_CCMD-1:0] LINE_MASK = 8'b1110_0000;

   typedef enum logic [2:0] {
      CC_INV_BOTH = 3'd0,
      CC_INV_ICACHE = 3'd1,
      CC_INV_DCACHE = 3'd2,
      CC_CLEAN_DCACHE = 3'd3,
      CC_FLUSH_DCACHE = 3'd4,
      CC_INV_LINE = 3'd5,
      CC_CLEAN_LINE = 3'd6,
      CC_FLUSH_LINE = 3'd7
   } ccmd_e;

   function automatic int unsigned ccmd_opcode(input ccmd_e c);
      case (c)
         CC_INV_BOTH: return 28;
         CC_INV_ICACHE: return 20;
         CC_INV_DCACHE: return 12;
         CC_CLEAN_DCACHE: return 10;
         CC_FLUSH_DCACHE: return 14;
         CC_INV_LINE: return 13;
         CC_CLEAN_LINE: return 11;
         default: return 15;
      endcase
   endfunction
endpackage

// File: rtl/ctlcop_wdec.sv
module ctlcop_wdec
   import ctlcop_pkg::*;
#(
   parameter int unsigned REG_W = 3,
   parameter int unsigned OP_W = 5
) (
   input logic wr_en,
   input logic [REG_W-1:0] reg_sel,
   input logic [OP_W-1:0] op_code,
   output logic [NUM_STORE-1:0] store_we,
   output logic [NUM_CCMD-1:0] ccmd_hit,
   output logic tlb_hit,
   output logic wr_err
);
   localparam logic [REG_W-1:0] SEL_CACHE = REG_W'(REG_CACHE);
   localparam logic [REG_W-1:0] SEL_TLB = REG_W'(REG_TLB);
   localparam logic [REG_W-1:0] SEL_LO = REG_W'(REG_STORE_LO);
   localparam logic [REG_W-1:0] SEL_HI = REG_W'(REG_STORE_LO + NUM_STORE - 1);

   logic op_zero;
   logic sel_store;
   logic sel_maint;

   assign op_zero = (op_code == '0);
   assign sel_store = (reg_sel >= SEL_LO) && (reg_sel <= SEL_HI);
   assign sel_maint = (reg_sel == SEL_CACHE) || (reg_sel == SEL_TLB);

   for (genvar i = 0; i < NUM_STORE; i++) begin : g_we
      assign store_we[i] = wr_en && op_zero && (reg_sel == REG_W'(REG_STORE_LO + i));
   end

   for (genvar c = 0; c < NUM_CCMD; c++) begin : g_ccmd
      localparam logic [OP_W-1:0] OPC = OP_W'(ccmd_opcode(ccmd_e'(c)));
      assign ccmd_hit[c] = wr_en && (reg_sel == SEL_CACHE) && (op_code == OPC);
   end

   assign tlb_hit = wr_en && (reg_sel == SEL_TLB)
                 && (op_code >= OP_W'(TLB_OP_LO)) && (op_code <= OP_W'(TLB_OP_HI));

   assign wr_err = wr_en && ((sel_store && !op_zero) || (!sel_store && !sel_maint));
endmodule

// File: rtl/ctlcop_store.sv
module ctlcop_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NREG = 4
) (
   input logic clk,
   input logic rst,
   input logic [NREG-1:0] we,
   input logic [DATA_W-1:0] wdata,
   output logic [NREG-1:0][DATA_W-1:0] q
);
   for (genvar i = 0; i < NREG; i++) begin : g_slot
      logic [DATA_W-1:0] val_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            val_q <= '0;
         end else if (we[i]) begin
            val_q <= wdata;
         end
      end
      assign q[i] = val_q;
   end
endmodule

// File: rtl/ctlcop_rmux.sv
module ctlcop_rmux
   import ctlcop_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_W = 3,
   parameter int unsigned OP_W = 5,
   parameter logic [DATA_W-1:0] ID_WORD = '0,
   parameter logic [DATA_W-1:0] CTYPE_WORD = '0
) (
   input logic rd_en,
   input logic [REG_W-1:0] reg_sel,
   input logic [OP_W-1:0] op_code,
   input logic [NUM_STORE-1:0][DATA_W-1:0] store_q,
   output logic [DATA_W-1:0] rdata,
   output logic rd_err
);
   logic [NUM_STORE-1:0] st_hit;
   logic id_hit;
   logic ct_hit;

   for (genvar i = 0; i < NUM_STORE; i++) begin : g_hit
      assign st_hit[i] = (reg_sel == REG_W'(REG_STORE_LO + i)) && (op_code == '0);
   end
   assign id_hit = (reg_sel == REG_W'(REG_ID)) && (op_code == OP_W'(0));
   assign ct_hit = (reg_sel == REG_W'(REG_ID)) && (op_code == OP_W'(1));

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (id_hit) rdata = ID_WORD;
         if (ct_hit) rdata = CTYPE_WORD;
         for (int i = 0; i < NUM_STORE; i++) begin
            if (st_hit[i]) rdata = store_q[i];
         end
      end
   end

   assign rd_err = rd_en && !(id_hit || ct_hit || (|st_hit));
endmodule

// File: rtl/ctlcop_unit.sv
module ctlcop_unit
   import ctlcop_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_W = 3,
   parameter int unsigned OP_W = 5,
   parameter logic [DATA_W-1:0] ID_WORD = 32'h4D11_0863,
   parameter logic [DATA_W-1:0] CTYPE_WORD = 32'h1D19_2D92
) (
   input logic clk,
   input logic rst,
   input logic wr_en,
   input logic rd_en,
   input logic [REG_W-1:0] reg_sel,
   input logic [OP_W-1:0] op_code,
   input logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NUM_CCMD-1:0] cache_cmd,
   output logic [DATA_W-1:0] line_addr,
   output logic tlb_flush,
   output logic access_err,
   input logic irq_req,
   input logic irq_mask,
   output logic irq_take
);
   if (REG_W < 3) begin : g_bad_reg_w
      $error("ctlcop_unit: REG_W must be at least 3");
   end
   if (OP_W < 5) begin : g_bad_op_w
      $error("ctlcop_unit: OP_W must be at least 5");
   end
   if (DATA_W < 8) begin : g_bad_data_w
      $error("ctlcop_unit: DATA_W must be at least 8");
   end

   logic [NUM_STORE-1:0] store_we;
   logic [NUM_CCMD-1:0] ccmd_hit;
   logic tlb_hit;
   logic wr_err;
   logic rd_err;
   logic [NUM_STORE-1:0][DATA_W-1:0] store_q;

   ctlcop_wdec #(.REG_W(REG_W), .OP_W(OP_W)) wdec_i (
      .wr_en(wr_en), .reg_sel(reg_sel), .op_code(op_code),
      .store_we(store_we), .ccmd_hit(ccmd_hit), .tlb_hit(tlb_hit), .wr_err(wr_err)
   );

   ctlcop_store #(.DATA_W(DATA_W), .NREG(NUM_STORE)) store_i (
      .clk(clk), .rst(rst), .we(store_we), .wdata(wdata), .q(store_q)
   );

   ctlcop_rmux #(
      .DATA_W(DATA_W), .REG_W(REG_W), .OP_W(OP_W),
      .ID_WORD(ID_WORD), .CTYPE_WORD(CTYPE_WORD)
   ) rmux_i (
      .rd_en(rd_en), .reg_sel(reg_sel), .op_code(op_code),
      .store_q(store_q), .rdata(rdata), .rd_err(rd_err)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cache_cmd <= '0;
         line_addr <= '0;
         tlb_flush <= 1'b0;
         access_err <= 1'b0;
      end else begin
         cache_cmd <= ccmd_hit;
         line_addr <= (|(ccmd_hit & LINE_MASK)) ? wdata : '0;
         tlb_flush <= tlb_hit;
         access_err <= wr_err || rd_err;
      end
   end

   assign irq_take = irq_req && !irq_mask;
endmodule

// File: rtl/ctlcop_chk.sv
module ctlcop_chk
   import ctlcop_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_W = 3,
   parameter int unsigned OP_W = 5
) (
   input logic clk,
   input logic rst,
   input logic wr_en,
   input logic rd_en,
   input logic [REG_W-1:0] reg_sel,
   input logic [OP_W-1:0] op_code,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [NUM_CCMD-1:0] cache_cmd,
   input logic [DATA_W-1:0] line_addr,
   input logic tlb_flush,
   input logic access_err,
   input logic irq_req,
   input logic irq_mask,
   input logic irq_take
);
   AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(cache_cmd)); // R5
   AST_CMD_SOURCE: assert property (@(posedge clk) disable iff (rst)
      (cache_cmd != '0) |-> ($past(wr_en) && $past(reg_sel) == REG_W'(REG_CACHE))); // R5
   AST_LINE_IDLE: assert property (@(posedge clk) disable iff (rst)
      ((cache_cmd & LINE_MASK) == '0) |-> (line_addr == '0)); // R6
   AST_LINE_DATA: assert property (@(posedge clk) disable iff (rst)
      ((cache_cmd & LINE_MASK) != '0) |-> (line_addr == $past(wdata))); // R6
   AST_TLB_SOURCE: assert property (@(posedge clk) disable iff (rst)
      tlb_flush |-> ($past(wr_en) && $past(reg_sel) == REG_W'(REG_TLB))); // R7
   AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (rst)
      access_err |-> ($past(wr_en) || $past(rd_en))); // R4
   AST_STORE_READ: assert property (@(posedge clk) disable iff (rst)
      (rd_en && reg_sel == REG_W'(1) && op_code == '0
       && $past(wr_en && reg_sel == REG_W'(1) && op_code == '0))
      |-> (rdata == $past(wdata))); // R2
   AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !rd_en |-> (rdata == '0)); // R4
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
      irq_mask |-> !irq_take); // R9
   AST_IRQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (irq_req && !irq_mask) |-> irq_take); // R9
endmodule

bind ctlcop_unit ctlcop_chk #(.DATA_W(DATA_W), .REG_W(REG_W), .OP_W(OP_W)) chk_i (
   .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
   .op_code(op_code), .wdata(wdata), .rdata(rdata), .cache_cmd(cache_cmd),
   .line_addr(line_addr), .tlb_flush(tlb_flush), .access_err(access_err),
   .irq_req(irq_req), .irq_mask(irq_mask), .irq_take(irq_take)
);

// File: tb/ctlcop_unit_tb_top.sv
module ctlcop_unit_tb_top;
   localparam int CLK_P = 10;
   localparam logic [31:0] IDW = 32'h4D11_0863;
   localparam logic [31:0] CTW = 32'h1D19_2D92;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wr_en = 1'b0;
   logic rd_en = 1'b0;
   logic [2:0] reg_sel = '0;
   logic [4:0] op_code = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [7:0] cache_cmd;
   logic [31:0] line_addr;
   logic tlb_flush;
   logic access_err;
   logic irq_req = 1'b0;
   logic irq_mask = 1'b0;
   logic irq_take;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] model [1:4];

   always #(CLK_P/2) clk = ~clk;

   ctlcop_unit #(.ID_WORD(IDW), .CTYPE_WORD(CTW)) dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
      .op_code(op_code), .wdata(wdata), .rdata(rdata), .cache_cmd(cache_cmd),
      .line_addr(line_addr), .tlb_flush(tlb_flush), .access_err(access_err),
      .irq_req(irq_req), .irq_mask(irq_mask), .irq_take(irq_take)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s reg=%0d op=%0d act=%h exp=%h", req, reg_sel, op_code, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_cmd(input int r, input int o);
      if (r != 5) return 8'h00;
      case (o)
         28: return 8'h01;
         20: return 8'h02;
         12: return 8'h04;
         10: return 8'h08;
         14: return 8'h10;
         13: return 8'h20;
         11: return 8'h40;
         15: return 8'h80;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic exp_wr_err(input int r, input int o);
      return (r == 0) || (r == 7) || (r >= 1 && r <= 4 && o != 0);
   endfunction

   // one write: strobe for one cycle, then check the registered pulses
   task automatic do_wr(input int r, input int o, input logic [31:0] d);
      logic [7:0] ec;
      @(negedge clk);
      wr_en = 1'b1; reg_sel = 3'(r); op_code = 5'(o); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      ec = exp_cmd(r, o);
      chk("R5 cache_cmd", {24'h0, cache_cmd}, {24'h0, ec});
      chk("R6 line_addr", line_addr, (ec & 8'hE0) != 0 ? d : 32'h0);
      chk("R7 tlb_flush", {31'h0, tlb_flush}, {31'h0, (r == 6 && o >= 2 && o <= 6)});
      chk("R3/R8 access_err", {31'h0, access_err}, {31'h0, exp_wr_err(r, o)});
      if (r >= 1 && r <= 4 && o == 0) model[r] = d;
      @(negedge clk);
      chk("R10 pulse width", {22'h0, cache_cmd, tlb_flush, access_err}, 32'h0);
   endtask

   task automatic do_rd(input int r, input int o);
      logic [31:0] ev;
      logic ok;
      @(negedge clk);
      rd_en = 1'b1; reg_sel = 3'(r); op_code = 5'(o);
      ok = 1'b1; ev = 32'h0;
      if (r == 0 && o == 0) ev = IDW;
      else if (r == 0 && o == 1) ev = CTW;
      else if (r >= 1 && r <= 4 && o == 0) ev = model[r];
      else ok = 1'b0;
      #1;
      if (r >= 1 && r <= 4) chk("R2/R3 rdata", rdata, ev);
      else chk("R4 rdata", rdata, ev);
      @(negedge clk);
      rd_en = 1'b0;
      chk("R4 read err", {31'h0, access_err}, {31'h0, !ok});
      #1;
      chk("R4 idle rdata", rdata, 32'h0);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 1; i <= 4; i++) model[i] = 32'h0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 outputs in reset", {22'h0, cache_cmd, tlb_flush, access_err}, 32'h0);
      chk("R1 line_addr in reset", line_addr, 32'h0);
      rst = 1'b0;
      for (int r = 1; r <= 4; r++) do_rd(r, 0);

      // R9: interrupt decision, all combinations
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         irq_req = k[0]; irq_mask = k[1];
         #1;
         chk("R9 irq_take", {31'h0, irq_take}, {31'h0, (k[0] && !k[1])});
      end
      irq_req = 1'b0; irq_mask = 1'b0;

      // exhaustive write sweep: all register numbers x all operation codes
      for (int r = 0; r < 8; r++) begin
         for (int o = 0; o < 32; o++) begin
            do_wr(r, o, 32'h5A00_0000 ^ (r * 32'h0001_0301) ^ (o * 32'h0004_1009));
         end
      end

      // exhaustive read sweep; stored values must equal the op-0 writes (R2, R3, R8)
      for (int r = 0; r < 8; r++) begin
         for (int o = 0; o < 32; o++) begin
            do_rd(r, o);
         end
      end

      // R10: back-to-back writes give adjacent, separate pulses
      @(negedge clk);
      wr_en = 1'b1; reg_sel = 3'd5; op_code = 5'd13; wdata = 32'hCAFE_0040;
      @(negedge clk);
      chk("R10 first pulse", {24'h0, cache_cmd}, 32'h20);
      chk("R10 first line", line_addr, 32'hCAFE_0040);
      reg_sel = 3'd6; op_code = 5'd2; wdata = 32'h1;
      @(negedge clk);
      chk("R10 second cmd clear", {24'h0, cache_cmd}, 32'h0);
      chk("R10 second tlb", {31'h0, tlb_flush}, 32'h1);
      reg_sel = 3'd7; op_code = 5'd0;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R10 third err", {30'h0, tlb_flush, access_err}, 32'h1);
      @(negedge clk);
      chk("R10 all quiet", {22'h0, cache_cmd, tlb_flush, access_err}, 32'h0);

      // R1: reset again clears storage
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int i = 1; i <= 4; i++) model[i] = 32'h0;
      for (int r = 1; r <= 4; r++) do_rd(r, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule